// File: doc/BRIEF.md
# Quad-Channel Double-Buffered Converter Command Port

This block is the digital front end of a four-channel, 8-bit converter. A host frames 12-bit command words with an active-low chip select and shifts them in on the rising edge of a serial clock. The port uses clock polarity 0 and phase 0. Each channel owns two registers. The staging (input) register takes new codes. The output (DAC) register holds the code that the converter actually uses. A command can stage one channel, move all staged codes to the outputs, or do both in one step. Moving all staged codes at once is how every output changes together.

Two active-low level pins act outside the serial protocol. The update pin makes every output register follow its staging register for as long as it is held low. The clear pin holds all eight registers at zero. A serial data output replays each bit twelve clocks after it entered, so several devices can share one chip select and one data line in a chain. It changes on the falling serial-clock edge.

All pins are brought into the block's own clock domain through a two-stage synchroniser. A small frame state machine then decides whether a word is run or thrown away. The states are IDLE, FRAME, EXEC and DROP. The transitions are start (IDLE to FRAME when chip select is low), accept (FRAME to EXEC when chip select rises after exactly twelve clocks), reject (FRAME to DROP when chip select rises after any other count), and done (EXEC or DROP back to IDLE).

Top module: `dacif_quad`

## Requirements
- R1: After reset every staging register, every output register and the serial data output are zero.
- R2: Word layout, shifted MSB first and sampled on rising serial clock: bits 11:10 are the channel (0 to 3), bits 9:8 are the operation, and bits 7:0 are the code. Channel n appears at bits [8n+7:8n] of `in_code` and `dac_code`.
- R3: Operation 01 writes the code into the addressed staging register only. The other staging registers and all output registers keep their values.
- R4: Operation 00 copies all four staging registers into their output registers. The staging registers keep their values.
- R5: Operation 11 writes the addressed staging register and, in the same command, copies all four staging registers (including the new code) into the output registers.
- R6: Operation 10 changes no register.
- R7: A frame whose chip-select rise follows any count of rising clocks other than twelve changes no register.
- R8: A command takes effect only after chip select rises. Twelve clocks with chip select still low leave every register unchanged.
- R9: The serial data output changes only after a falling serial-clock edge. Before rising edge k of a frame (k counted from 0, with k at least 12), it carries the bit that was shifted in at rising edge k-12.
- R10: While `ldac_n` is low, every output register follows its staging register, including codes written by commands that complete while the pin is low.
- R11: While `clr_n` is low, all eight registers are zero and commands do not load them. The registers stay zero after the pin is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all pins are sampled in this domain |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low frame select |
| sclk | input | 1 | Serial clock, data sampled on rising edge |
| din | input | 1 | Serial data in, MSB first |
| ldac_n | input | 1 | Active-low level: outputs follow staging registers |
| clr_n | input | 1 | Active-low level: zero all registers |
| dout | output | 1 | Chained serial data out, changes on falling sclk |
| in_code | output | NCH*DW | Staging registers, channel n at [DW*n+DW-1:DW*n] |
| dac_code | output | NCH*DW | Output registers, channel n at [DW*n+DW-1:DW*n] |

## Verification
A wrong bit count or a frame state stuck in FRAME shows up as a missed or extra register write. That error appears on `in_code` or `dac_code` a few block clocks after the chip-select rise of the affected word. A corrupted shift register shows up on `dout` in the next frame, twelve serial clocks after the bad bit entered. A staging register that is wrong but has not yet been copied stays hidden from `dac_code` until the next transfer. `in_code` is brought out so that such an error is seen at once.

// File: rtl/dacif_pkg.sv
package dacif_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FRAME = 2'd1,
        ST_EXEC  = 2'd2,
        ST_DROP  = 2'd3
    } dacif_state_e;

    typedef enum logic [1:0] {
        OP_XFER     = 2'b00,
        OP_LOAD     = 2'b01,
        OP_NOP      = 2'b10,
        OP_LOADXFER = 2'b11
    } dacif_op_e;

endpackage

// File: rtl/dacif_sync.sv
module dacif_sync #(
    parameter int W = 1,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= RST_VAL;
        end else begin
            stage_q[0] <= d;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/dacif_serial_rx.sv
module dacif_serial_rx #(
    parameter int WORD_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_s,
    input  logic              cs_n_s,
    input  logic              din_s,
    output logic [WORD_W-1:0] word,
    output logic              cnt_ok,
    output logic              cs_rise,
    output logic              sclk_fall,
    output logic              dout
);
    localparam int SAT = WORD_W + 1;
    localparam int CW  = $clog2(SAT + 1);

    logic          sclk_q, csn_q;
    logic          sclk_rise, cs_fall;
    logic [CW-1:0] cnt_q;

    assign sclk_rise = sclk_s & ~sclk_q;
    assign sclk_fall = ~sclk_s & sclk_q;
    assign cs_fall   = ~cs_n_s & csn_q;
    assign cs_rise   = cs_n_s & ~csn_q;
    assign cnt_ok    = (cnt_q == CW'(WORD_W));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_q <= 1'b0;
            csn_q  <= 1'b1;
        end else begin
            sclk_q <= sclk_s;
            csn_q  <= cs_n_s;
        end
    end

    // shift register and saturating bit counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word  <= '0;
            cnt_q <= '0;
        end else if (cs_fall) begin
            cnt_q <= '0;
        end else if (sclk_rise && !cs_n_s) begin
            word <= {word[WORD_W-2:0], din_s};
            if (cnt_q != CW'(SAT)) cnt_q <= cnt_q + 1'b1;
        end
    end

    // chained output launched on the falling serial edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    dout <= 1'b0;
        else if (sclk_fall && !cs_n_s) dout <= word[WORD_W-1];
    end
endmodule

// File: rtl/dacif_bank.sv
module dacif_bank #(
    parameter int NCH = 4,
    parameter int DW  = 8,
    parameter int AW  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              ldac,
    input  logic              ld_in,
    input  logic              ld_xfer,
    input  logic [AW-1:0]     addr,
    input  logic [DW-1:0]     data,
    output logic [NCH*DW-1:0] in_flat,
    output logic [NCH*DW-1:0] dac_flat
);
    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        logic [DW-1:0] in_r, dac_r, in_next;

        assign in_next = (ld_in && addr == AW'(ch)) ? data : in_r;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                in_r  <= '0;
                dac_r <= '0;
            end else if (clr) begin
                in_r  <= '0;
                dac_r <= '0;
            end else begin
                in_r <= in_next;
                if (ld_xfer || ldac) dac_r <= in_next;
            end
        end

        assign in_flat[DW*ch +: DW]  = in_r;
        assign dac_flat[DW*ch +: DW] = dac_r;
    end
endmodule

// File: rtl/dacif_quad.sv
module dacif_quad
    import dacif_pkg::*;
#(
    parameter int NCH = 4,
    parameter int DW = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              din,
    input  logic              ldac_n,
    input  logic              clr_n,
    output logic              dout,
    output logic [NCH*DW-1:0] in_code,
    output logic [NCH*DW-1:0] dac_code
);
    localparam int AW     = (NCH > 1) ? $clog2(NCH) : 1;
    localparam int CTW    = 2;
    localparam int WORD_W = AW + CTW + DW;

    logic [4:0] pins_raw, pins_s;
    logic       cs_n_s, sclk_s, din_s, ldac_act, clr_act;

    assign pins_raw = {cs_n, sclk, din, ldac_n, clr_n};

    dacif_sync #(.W(5), .STAGES(SYNC_STAGES), .RST_VAL(5'b10011)) sync_i (
        .clk(clk), .rst_n(rst_n), .d(pins_raw), .q(pins_s)
    );

    assign cs_n_s   = pins_s[4];
    assign sclk_s   = pins_s[3];
    assign din_s    = pins_s[2];
    assign ldac_act = ~pins_s[1];
    assign clr_act  = ~pins_s[0];

    logic [WORD_W-1:0] word;
    logic              cnt_ok, cs_rise, sclk_fall;

    dacif_serial_rx #(.WORD_W(WORD_W)) rx_i (
        .clk(clk), .rst_n(rst_n), .sclk_s(sclk_s), .cs_n_s(cs_n_s), .din_s(din_s),
        .word(word), .cnt_ok(cnt_ok), .cs_rise(cs_rise), .sclk_fall(sclk_fall),
        .dout(dout)
    );

    // word fields
    logic [AW-1:0] addr;
    dacif_op_e     op;
    logic [DW-1:0] data;

    assign addr = word[WORD_W-1 -: AW];
    assign op   = dacif_op_e'(word[DW+CTW-1 -: CTW]);
    assign data = word[DW-1:0];

    // frame state machine: state register
    dacif_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state: start, accept, reject, done
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (!cs_n_s) state_d = ST_FRAME;
            ST_FRAME: if (cs_rise) state_d = cnt_ok ? ST_EXEC : ST_DROP;
            ST_EXEC:  state_d = ST_IDLE;
            ST_DROP:  state_d = ST_IDLE;
        endcase
    end

    // state outputs: command strobes
    logic ld_in, ld_xfer;

    always_comb begin
        ld_in   = 1'b0;
        ld_xfer = 1'b0;
        if (state_q == ST_EXEC) begin
            unique case (op)
                OP_XFER:     ld_xfer = 1'b1;
                OP_LOAD:     ld_in   = 1'b1;
                OP_NOP:      ;
                OP_LOADXFER: begin ld_in = 1'b1; ld_xfer = 1'b1; end
            endcase
        end
    end

    dacif_bank #(.NCH(NCH), .DW(DW), .AW(AW)) bank_i (
        .clk(clk), .rst_n(rst_n), .clr(clr_act), .ldac(ldac_act),
        .ld_in(ld_in), .ld_xfer(ld_xfer), .addr(addr), .data(data),
        .in_flat(in_code), .dac_flat(dac_code)
    );
endmodule

// File: rtl/dacif_quad_chk.sv
module dacif_quad_chk
    import dacif_pkg::*;
#(
    parameter int NCH = 4,
    parameter int DW = 8
) (
    input logic              clk,
    input logic              rst_n,
    input dacif_state_e      state,
    input dacif_op_e         op,
    input logic              clr_a,
    input logic              ldac_a,
    input logic              sclk_fall,
    input logic              dout,
    input logic [NCH*DW-1:0] in_code,
    input logic [NCH*DW-1:0] dac_code
);
    // R8: outputs move only after an executed command or a pin action
    a_r8_dac_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dac_code) |-> ($past(state) == ST_EXEC || $past(ldac_a) || $past(clr_a)));

    a_r8_in_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(in_code) |-> ($past(state) == ST_EXEC || $past(clr_a)));

    a_r11_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr_a |=> (in_code == '0 && dac_code == '0));

    a_r7_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DROP && !clr_a) |=> $stable(in_code));

    a_r9_dout_edge: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dout) |-> $past(sclk_fall));

    a_r6_nop: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EXEC && op == OP_NOP && !clr_a && !ldac_a) |=> ($stable(in_code) && $stable(dac_code)));

    a_r3_load_only: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EXEC && op == OP_LOAD && !clr_a && !ldac_a) |=> $stable(dac_code));

    a_r4_xfer: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EXEC && op == OP_XFER && !clr_a) |=> ($stable(in_code) && dac_code == in_code));
endmodule

bind dacif_quad dacif_quad_chk #(.NCH(NCH), .DW(DW)) chk_i (
    .clk(clk), .rst_n(rst_n), .state(state_q), .op(op), .clr_a(clr_act),
    .ldac_a(ldac_act), .sclk_fall(sclk_fall), .dout(dout),
    .in_code(in_code), .dac_code(dac_code)
);

// File: tb/dacif_quad_tb.sv
module dacif_quad_tb_top;
    localparam int NCH = 4;
    localparam int DW  = 8;
    localparam int FW  = NCH * DW;
    localparam int HP  = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, sclk = 1'b0, din = 1'b0, ldac_n = 1'b1, clr_n = 1'b1;
    logic dout;
    logic [FW-1:0] in_code, dac_code;

    always #2 clk = ~clk;

    dacif_quad #(.NCH(NCH), .DW(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .din(din),
        .ldac_n(ldac_n), .clr_n(clr_n), .dout(dout),
        .in_code(in_code), .dac_code(dac_code)
    );

    int   n_chk = 0, n_bad = 0;
    bit   done = 0;
    logic [DW-1:0] m_in [NCH];
    logic [DW-1:0] m_dac[NCH];
    logic dout_seen[64];

    function automatic logic [FW-1:0] pack_in();
        logic [FW-1:0] v;
        for (int i = 0; i < NCH; i++) v[DW*i +: DW] = m_in[i];
        return v;
    endfunction

    function automatic logic [FW-1:0] pack_dac();
        logic [FW-1:0] v;
        for (int i = 0; i < NCH; i++) v[DW*i +: DW] = m_dac[i];
        return v;
    endfunction

    // model of one accepted 12-bit word
    function automatic void model_word(logic [11:0] w);
        int a = int'(w[11:10]);
        if (!clr_n) return;
        if (w[9:8] == 2'b01 || w[9:8] == 2'b11) m_in[a] = w[7:0];
        if (w[9:8] == 2'b00 || w[9:8] == 2'b11 || !ldac_n)
            for (int i = 0; i < NCH; i++) m_dac[i] = m_in[i];
    endfunction

    task automatic wait_clk(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(string req, logic [FW-1:0] act, logic [FW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_regs(string req);
        check({req, " in"}, in_code, pack_in());
        check({req, " dac"}, dac_code, pack_dac());
    endtask

    // shift n bits of w MSB first; raise_cs ends the frame
    task automatic shift_bits(logic [63:0] w, int n, bit raise_cs);
        cs_n = 1'b0;
        wait_clk(HP);
        for (int k = 0; k < n; k++) begin
            din = w[n-1-k];
            wait_clk(HP);
            dout_seen[k] = dout;
            sclk = 1'b1;
            wait_clk(HP);
            sclk = 1'b0;
        end
        wait_clk(HP);
        if (raise_cs) begin
            cs_n = 1'b1;
            wait_clk(10);
        end
    endtask

    task automatic send_word(logic [11:0] w);
        shift_bits({52'd0, w}, 12, 1'b1);
        model_word(w);
    endtask

    initial begin
        for (int i = 0; i < NCH; i++) begin m_in[i] = '0; m_dac[i] = '0; end
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(5);
        // R1 reset state
        check_regs("R1");
        check("R1 dout", FW'(dout), '0);

        // R3 / R2: stage each channel, outputs untouched
        for (int c = 0; c < NCH; c++) begin
            send_word({2'(c), 2'b01, 8'(8'h11 * (c + 1))});
            check_regs("R3 R2");
        end
        // R4 transfer all
        send_word({2'd0, 2'b00, 8'h00});
        check_regs("R4");
        // R5 stage and transfer in one word, top channel
        send_word({2'd3, 2'b11, 8'hff});
        check_regs("R5");
        // R6 no-op
        send_word({2'd1, 2'b10, 8'h5a});
        check_regs("R6");

        // R8: twelve clocks with chip select held low change nothing
        shift_bits({52'd0, 2'd2, 2'b11, 8'h3c}, 12, 1'b0);
        wait_clk(10);
        check_regs("R8 before rise");
        cs_n = 1'b1;
        wait_clk(10);
        model_word({2'd2, 2'b11, 8'h3c});
        check_regs("R8 after rise");

        // R7: short, long frames ignored
        shift_bits({52'd0, 2'd0, 2'b11, 8'h99} >> 1, 11, 1'b1);
        check_regs("R7 short");
        shift_bits({51'd0, 2'd0, 2'b11, 8'h99, 1'b1}, 13, 1'b1);
        check_regs("R7 long");

        // R9: two words in one 24-clock frame; dout replays the first
        begin
            logic [11:0] w1 = 12'b01_11_1010_0110;
            logic [11:0] w2 = 12'b10_01_0101_1001;
            shift_bits({40'd0, w1, w2}, 24, 1'b1);
            for (int k = 12; k < 24; k++)
                check($sformatf("R9 bit %0d", k), FW'(dout_seen[k]), FW'(w1[23-k]));
            check_regs("R7 24-bit frame");
        end

        // R10: update pin low makes outputs follow staging
        send_word({2'd1, 2'b01, 8'h42});
        ldac_n = 1'b0;
        wait_clk(8);
        for (int i = 0; i < NCH; i++) m_dac[i] = m_in[i];
        check_regs("R10 level");
        send_word({2'd0, 2'b01, 8'h81});
        check_regs("R10 during");
        ldac_n = 1'b1;
        wait_clk(8);
        check_regs("R10 release");

        // R11: clear pin zeroes and blocks loads
        clr_n = 1'b0;
        wait_clk(8);
        for (int i = 0; i < NCH; i++) begin m_in[i] = '0; m_dac[i] = '0; end
        check_regs("R11 clear");
        send_word({2'd2, 2'b11, 8'h77});
        check_regs("R11 blocked");
        clr_n = 1'b1;
        wait_clk(8);
        check_regs("R11 release");

        // random commands, seeded
        void'($urandom(32'd9071));
        for (int it = 0; it < 150; it++) begin
            logic [11:0] w = 12'($urandom);
            int sel = int'($urandom % 10);
            if (sel == 0) begin
                shift_bits({52'd0, w} >> 1, 11, 1'b1);
                check_regs("R7 rnd short");
            end else if (sel == 1) begin
                shift_bits({51'd0, w, 1'b0}, 13, 1'b1);
                check_regs("R7 rnd long");
            end else if (sel == 2) begin
                ldac_n = 1'b0;
                wait_clk(8);
                for (int i = 0; i < NCH; i++) m_dac[i] = m_in[i];
                send_word(w);
                ldac_n = 1'b1;
                wait_clk(8);
                check_regs("R10 rnd");
            end else begin
                send_word(w);
                check_regs("R2 R3 R4 R5 R6 rnd");
            end
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule